// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Burst Reader

This block runs a four-channel parallel converter that samples all of its inputs at the same instant. A free-running period counter fires a one-cycle low pulse on the conversion-start output. The pulse's rising edge freezes every track/hold at once and begins the conversion sequence. The block then waits for the converter's busy line to drop. Only after that falling edge does it walk through the enabled channels, from the lowest index upward, with a paired chip-select/read strobe for each one.

Each 14-bit result is widened with zeros to a 16-bit halfword. Two consecutive halfwords form one 32-bit word, which leaves on a valid/ready stream. The first sample read sits in the low half. A burst with an odd channel count ends with a word whose upper half is zero. The strobe period, the read pulse width and the channel mask are inputs. This lets one instance serve different sample rates and bus timings.

Top module: `adc_burst_reader`

## Requirements
- R1: A synchronous active-high reset drives convStN, csN and rdN high, and outValid and overrun low. This holds even while enable is high during reset.
- R2: While enable is high, the period counter advances once per clock. When it wraps every `divider` cycles, the block pulls convStN low for exactly one clock, provided a conversion is issued.
- R3: After a conversion start, no read strobe occurs until the block has seen a falling edge on adcBusy.
- R4: The block samples chanSel in the cycle it issues the start pulse. It performs one read for each set bit, in ascending bit order (bit 0 is channel 0). When chanSel is zero, no start pulse is issued and no read occurs.
- R5: csN and rdN go low together and stay low for rdLowCycles clocks, with a value of 0 acting as 1. adcData is captured on the last low cycle.
- R6: Each sample appears zero-extended in a 16-bit half. The first sample of a pair goes to outData[15:0] and the second to outData[31:16].
- R7: When an odd number of channels is enabled, the final word carries its sample in bits 15:0, and bits 31:16 are zero.
- R8: A presented word stays valid and unchanged until outReady is high. Once the packing register holds a complete word that cannot be presented, no further reads are started.
- R9: A period wrap that arrives while a conversion or read burst is in progress issues no start pulse. It sets overrun, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the period counter; low holds it at zero |
| divider | input | 16 | Start pulse period in clocks (values below 2 act as 2) |
| chanSel | input | 4 | Channel enable mask, bit n selects channel n |
| rdLowCycles | input | 4 | Read strobe low time in clocks (0 acts as 1) |
| convStN | output | 1 | Conversion start, active low, one-cycle pulse |
| adcBusy | input | 1 | Converter busy; falling edge ends the sequence |
| csN | output | 1 | Converter chip select, active low |
| rdN | output | 1 | Converter read strobe, active low |
| adcData | input | 14 | Converter parallel result bus |
| outData | output | 32 | Packed pair of 16-bit samples |
| outValid | output | 1 | outData holds a word |
| outReady | input | 1 | Consumer accepts the word |
| overrun | output | 1 | Sticky: a start period was skipped |

## Verification
The functions that can collide in one cycle are the period counter's wrap and an unfinished read burst. The wrap must then become a skipped start plus the overrun flag, never a second strobe. The bench provokes this with a short divider, all four channels enabled and long read pulses, so every burst spans more than one period. It then judges that overrun is set and that the gap between start pulses is a whole multiple of the divider, at least twice its value. A second collision is between a full packing register and a stalled output slot. The bench holds outReady low through a four-channel burst and checks that exactly four reads occur and that the first word stays frozen.

// File: rtl/abr_pkg.sv
package abr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_GAP,
    ST_READ,
    ST_PUSH
  } abrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic upperHalf;
    logic emit;
  } abrCtl_t;

endpackage

// File: rtl/abr_control.sv
module abr_control
  import abr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 16,
  parameter int RDW_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divider,
  input  logic [NUM_CH-1:0] chanSel,
  input  logic [RDW_W-1:0]  rdLowCycles,
  input  logic              adcBusy,
  input  logic              outValid,
  output logic              convStN,
  output logic              csN,
  output logic              rdN,
  output logic              overrun,
  output abrCtl_t           ctl
);

  abrState_t         state, stateNext;
  logic [DIV_W-1:0]  periodCnt;
  logic [DIV_W-1:0]  periodLimit;
  logic              periodTick;
  logic              busyPrev;
  logic              busyFall;
  logic              startConv;
  logic              overrunHit;
  logic [NUM_CH-1:0] remMask;
  logic [NUM_CH-1:0] curBit;
  logic [NUM_CH-1:0] remAfter;
  logic              halfSel;
  logic [RDW_W-1:0]  rdCnt;
  logic [RDW_W-1:0]  rdLimit;
  logic              lastRead;
  logic              wordDone;

  // period counter: wraps every max(divider,2) cycles
  assign periodLimit = (divider < DIV_W'(2)) ? DIV_W'(1) : divider - DIV_W'(1);
  assign periodTick  = enable && (periodCnt >= periodLimit);

  always_ff @(posedge clk) begin
    if (rst || !enable) periodCnt <= '0;
    else if (periodTick) periodCnt <= '0;
    else                 periodCnt <= periodCnt + DIV_W'(1);
  end

  assign busyFall   = busyPrev && !adcBusy;
  assign startConv  = periodTick && (state == ST_IDLE) && (|chanSel);
  assign overrunHit = periodTick && (state != ST_IDLE);

  // lowest pending channel first
  assign curBit   = remMask & (~remMask + NUM_CH'(1));
  assign remAfter = remMask & ~curBit;

  assign rdLimit  = (rdLowCycles == '0) ? '0 : rdLowCycles - RDW_W'(1);
  assign lastRead = (state == ST_READ) && (rdCnt == rdLimit);
  assign wordDone = halfSel || (remAfter == '0);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startConv) stateNext = ST_CONV;
      ST_CONV: if (busyFall)  stateNext = ST_GAP;
      ST_GAP:  stateNext = ST_READ;
      ST_READ: if (lastRead)  stateNext = wordDone ? ST_PUSH : ST_GAP;
      ST_PUSH: if (!outValid) stateNext = (remMask == '0) ? ST_IDLE : ST_GAP;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.capture   = lastRead;
    ctl.upperHalf = halfSel;
    ctl.emit      = (state == ST_PUSH) && !outValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busyPrev <= 1'b0;
      remMask  <= '0;
      halfSel  <= 1'b0;
      rdCnt    <= '0;
      convStN  <= 1'b1;
      csN      <= 1'b1;
      rdN      <= 1'b1;
      overrun  <= 1'b0;
    end else begin
      state    <= stateNext;
      busyPrev <= adcBusy;
      if (startConv)     remMask <= chanSel;
      else if (lastRead) remMask <= remAfter;
      if (startConv)     halfSel <= 1'b0;
      else if (lastRead) halfSel <= ~halfSel;
      rdCnt    <= (state == ST_READ && !lastRead) ? rdCnt + RDW_W'(1) : '0;
      convStN  <= !startConv;
      csN      <= !(stateNext == ST_READ);
      rdN      <= !(stateNext == ST_READ);
      overrun  <= overrun || overrunHit;
    end
  end

endmodule

// File: rtl/abr_datapath.sv
module abr_datapath
  import abr_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int HALF_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  abrCtl_t             ctl,
  input  logic [SAMPLE_W-1:0] adcData,
  input  logic                outReady,
  output logic [2*HALF_W-1:0] outData,
  output logic                outValid
);

  localparam int OUT_W = 2 * HALF_W;

  logic [HALF_W-1:0] sampleExt;
  logic [OUT_W-1:0]  packReg;

  assign sampleExt = {{(HALF_W - SAMPLE_W){1'b0}}, adcData};

  always_ff @(posedge clk) begin
    if (rst) begin
      packReg  <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      if (ctl.capture) begin
        if (ctl.upperHalf) packReg[OUT_W-1:HALF_W] <= sampleExt;
        else               packReg <= {{HALF_W{1'b0}}, sampleExt};
      end
      if (ctl.emit) begin
        outData  <= packReg;
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader
  import abr_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 14,
  parameter int HALF_W   = 16,
  parameter int DIV_W    = 16,
  parameter int RDW_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [DIV_W-1:0]    divider,
  input  logic [NUM_CH-1:0]   chanSel,
  input  logic [RDW_W-1:0]    rdLowCycles,
  output logic                convStN,
  input  logic                adcBusy,
  output logic                csN,
  output logic                rdN,
  input  logic [SAMPLE_W-1:0] adcData,
  output logic [2*HALF_W-1:0] outData,
  output logic                outValid,
  input  logic                outReady,
  output logic                overrun
);

  abrCtl_t ctl;

  abr_control #(
    .NUM_CH (NUM_CH),
    .DIV_W  (DIV_W),
    .RDW_W  (RDW_W)
  ) u_control (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .divider     (divider),
    .chanSel     (chanSel),
    .rdLowCycles (rdLowCycles),
    .adcBusy     (adcBusy),
    .outValid    (outValid),
    .convStN     (convStN),
    .csN         (csN),
    .rdN         (rdN),
    .overrun     (overrun),
    .ctl         (ctl)
  );

  abr_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .HALF_W   (HALF_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .adcData  (adcData),
    .outReady (outReady),
    .outData  (outData),
    .outValid (outValid)
  );

endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
  parameter int SAMPLE_W = 14,
  parameter int HALF_W   = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                convStN,
  input logic                csN,
  input logic                rdN,
  input logic [2*HALF_W-1:0] outData,
  input logic                outValid,
  input logic                outReady,
  input logic                overrun
);

  // R2
  conv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !convStN |=> convStN);

  // R3
  no_read_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    !convStN |-> rdN);

  // R5
  strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    csN == rdN);

  // R6
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outData[HALF_W-1:SAMPLE_W] == '0 && outData[2*HALF_W-1:HALF_W+SAMPLE_W] == '0));

  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

endmodule

bind adc_burst_reader abr_checker #(
  .SAMPLE_W (SAMPLE_W),
  .HALF_W   (HALF_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .convStN  (convStN),
  .csN      (csN),
  .rdN      (rdN),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .overrun  (overrun)
);

// File: tb/adc_burst_reader_tb.sv
module adc_burst_reader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] divider = 16'd300;
  logic [3:0]  chanSel = 4'h0;
  logic [3:0]  rdLowCycles = 4'd1;
  logic        convStN, csN, rdN;
  logic        adcBusy = 1'b0;
  logic [13:0] adcData;
  logic [31:0] outData;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        overrun;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_burst_reader u_dut (
    .clk(clk), .rst(rst), .enable(enable), .divider(divider),
    .chanSel(chanSel), .rdLowCycles(rdLowCycles), .convStN(convStN),
    .adcBusy(adcBusy), .csN(csN), .rdN(rdN), .adcData(adcData),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .overrun(overrun)
  );

  // ---------------- behavioural converter stub ----------------
  logic       convPrev = 1'b1;
  logic       rdPrev   = 1'b1;
  int         busyLeft = 0;
  int         stubConv = 0;
  logic [3:0] stubRem  = 4'h0;

  function automatic logic [1:0] lowIdx(input logic [3:0] m);
    for (int i = 3; i >= 0; i--) if (m[i]) lowIdx = 2'(i);
    if (m == 4'h0) lowIdx = 2'd0;
  endfunction

  function automatic logic [13:0] sampleVal(input int n, input int c);
    logic [7:0] nb;
    logic [1:0] cb;
    nb = 8'(n);
    cb = 2'(c);
    sampleVal = {nb, 4'b1010, cb};
  endfunction

  always @(posedge clk) begin
    convPrev <= convStN;
    rdPrev   <= rdN;
    if (!rdPrev && rdN) stubRem <= stubRem & ~(4'h1 << lowIdx(stubRem));
    if (!convPrev && convStN) begin
      adcBusy  <= 1'b1;
      busyLeft <= BUSY_CYC;
      stubConv <= stubConv + 1;
      stubRem  <= chanSel;
    end else if (busyLeft > 0) begin
      busyLeft <= busyLeft - 1;
      if (busyLeft == 1) adcBusy <= 1'b0;
    end
  end

  always_comb adcData = (!csN && !rdN) ? sampleVal(stubConv, int'(lowIdx(stubRem))) : 14'h3FFF;

  // ---------------- monitor (negedge) ----------------
  int   cyc = 0, convFalls = 0, lastConvCyc = 0, lastSpacing = 0, minSpacing = 1000000;
  int   convRun = 0, convWidth = 0;
  int   rdCur = 0, rdPulses = 0, rdWidthMin = 1000, rdWidthMax = 0, rdDuringWait = 0;
  int   gotCnt = 0;
  logic waitBusy = 1'b0;
  logic prevConvM = 1'b1, prevRdM = 1'b1, prevBusyM = 1'b0;
  logic [31:0] got [0:15];

  always @(negedge clk) begin
    cyc++;
    if (!convStN && prevConvM) begin
      convFalls++;
      if (lastConvCyc > 0) begin
        lastSpacing = cyc - lastConvCyc;
        if (lastSpacing < minSpacing) minSpacing = lastSpacing;
      end
      lastConvCyc = cyc;
      waitBusy = 1'b1;
    end
    if (!convStN) convRun++;
    else if (!prevConvM) begin convWidth = convRun; convRun = 0; end
    if (prevBusyM && !adcBusy) waitBusy = 1'b0;
    if (!rdN && waitBusy) rdDuringWait++;
    if (!rdN) rdCur++;
    else if (!prevRdM) begin
      rdPulses++;
      if (rdCur < rdWidthMin) rdWidthMin = rdCur;
      if (rdCur > rdWidthMax) rdWidthMax = rdCur;
      rdCur = 0;
    end
    if (outValid && outReady && !rst) begin
      if (gotCnt < 16) got[gotCnt] = outData;
      gotCnt++;
    end
    prevConvM = convStN;
    prevRdM   = rdN;
    prevBusyM = adcBusy;
  end

  task automatic clearStats();
    @(posedge clk); #1;
    convFalls = 0; lastConvCyc = 0; lastSpacing = 0; minSpacing = 1000000;
    convWidth = 0; rdPulses = 0; rdWidthMin = 1000; rdWidthMax = 0;
    rdDuringWait = 0; gotCnt = 0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [3:0] sel, input int n, input int j);
    logic [15:0] hw [0:3];
    int k;
    k = 0;
    for (int c = 0; c < 4; c++) if (sel[c]) begin hw[k] = {2'b00, sampleVal(n, c)}; k++; end
    expWord = {(2*j+1 < k) ? hw[2*j+1] : 16'h0000, hw[2*j]};
  endfunction

  function automatic int popc(input logic [3:0] s);
    popc = 0;
    for (int c = 0; c < 4; c++) if (s[c]) popc++;
  endfunction

  task automatic startOne();
    int t;
    enable = 1'b1;
    t = 0;
    while (convFalls == 0 && t < 1000) begin waitCycles(1); t++; end
    enable = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    rst = 1'b1; enable = 1'b1; chanSel = 4'hF; divider = 16'd3;
    waitCycles(8);
    check(convStN == 1'b1, "R1", "convStN in reset", 32'(convStN), 32'h1);
    check(csN == 1'b1 && rdN == 1'b1, "R1", "csN/rdN in reset", {30'h0, csN, rdN}, 32'h3);
    check(outValid == 1'b0, "R1", "outValid in reset", 32'(outValid), 32'h0);
    check(overrun == 1'b0, "R1", "overrun in reset", 32'(overrun), 32'h0);
    enable = 1'b0; divider = 16'd300;
    rst = 1'b0;
    waitCycles(2);
  endtask

  task automatic testBurst(input logic [3:0] sel, input logic [3:0] rdw);
    int t, nw, w;
    chanSel = sel; rdLowCycles = rdw; divider = 16'd300;
    clearStats();
    startOne();
    nw = (popc(sel) + 1) / 2;
    t = 0;
    while (gotCnt < nw && t < 400) begin waitCycles(1); t++; end
    waitCycles(10);
    w = (rdw == 0) ? 1 : int'(rdw);
    check(convWidth == 1, "R2", "start pulse width", 32'(convWidth), 32'd1);
    check(rdDuringWait == 0, "R3", "reads before busy fall", 32'(rdDuringWait), 32'd0);
    check(rdPulses == popc(sel), "R4", "read count", 32'(rdPulses), 32'(popc(sel)));
    check(gotCnt == nw, "R4", "word count", 32'(gotCnt), 32'(nw));
    check(rdWidthMin == w && rdWidthMax == w, "R5", "read low width",
          32'(rdWidthMax), 32'(w));
    for (int j = 0; j < nw && j < gotCnt; j++) begin
      if (popc(sel) % 2 == 1 && j == nw - 1)
        check(got[j] == expWord(sel, stubConv, j), "R7", "padded word", got[j], expWord(sel, stubConv, j));
      else
        check(got[j] == expWord(sel, stubConv, j), "R6", "packed word", got[j], expWord(sel, stubConv, j));
    end
  endtask

  task automatic testNoChannels();
    chanSel = 4'h0; divider = 16'd20;
    clearStats();
    enable = 1'b1;
    waitCycles(100);
    enable = 1'b0;
    waitCycles(2);
    check(convFalls == 0, "R4", "start pulses with empty mask", 32'(convFalls), 32'd0);
    check(rdPulses == 0, "R4", "reads with empty mask", 32'(rdPulses), 32'd0);
    check(overrun == 1'b0, "R9", "no overrun when idle", 32'(overrun), 32'd0);
  endtask

  task automatic testPeriod();
    chanSel = 4'h1; rdLowCycles = 4'd1; divider = 16'd80;
    clearStats();
    enable = 1'b1;
    waitCycles(330);
    enable = 1'b0;
    waitCycles(60);
    check(convFalls >= 4, "R2", "start pulse count", 32'(convFalls), 32'd4);
    check(minSpacing == 80 && lastSpacing == 80, "R2", "start pulse period",
          32'(lastSpacing), 32'd80);
    check(convWidth == 1, "R2", "start pulse width", 32'(convWidth), 32'd1);
    check(overrun == 1'b0, "R9", "no overrun at slow rate", 32'(overrun), 32'd0);
  endtask

  task automatic testStall();
    logic [31:0] held;
    chanSel = 4'hF; rdLowCycles = 4'd2; divider = 16'd300;
    outReady = 1'b0;
    clearStats();
    startOne();
    waitCycles(150);
    held = outData;
    check(outValid == 1'b1, "R8", "word held valid", 32'(outValid), 32'd1);
    check(outData == expWord(4'hF, stubConv, 0), "R8", "held word value", outData, expWord(4'hF, stubConv, 0));
    check(rdPulses == 4, "R8", "reads while stalled", 32'(rdPulses), 32'd4);
    waitCycles(20);
    check(outData == held && outValid, "R8", "word stable", outData, held);
    outReady = 1'b1;
    waitCycles(20);
    check(gotCnt == 2, "R8", "words after release", 32'(gotCnt), 32'd2);
    check(got[1] == expWord(4'hF, stubConv, 1), "R6", "second word after stall", got[1], expWord(4'hF, stubConv, 1));
  endtask

  task automatic testOverrun();
    chanSel = 4'hF; rdLowCycles = 4'd6; divider = 16'd16;
    clearStats();
    enable = 1'b1;
    waitCycles(250);
    enable = 1'b0;
    waitCycles(100);
    check(overrun == 1'b1, "R9", "overrun set", 32'(overrun), 32'd1);
    check(minSpacing >= 32 && (minSpacing % 16) == 0, "R9", "skipped start spacing",
          32'(minSpacing), 32'd48);
    check(rdDuringWait == 0, "R3", "reads before busy fall (fast)", 32'(rdDuringWait), 32'd0);
    check(convWidth == 1, "R2", "start pulse width (fast)", 32'(convWidth), 32'd1);
    rst = 1'b1;
    waitCycles(2);
    check(overrun == 1'b0, "R1", "reset clears overrun", 32'(overrun), 32'd0);
    rst = 1'b0;
    waitCycles(2);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testBurst(4'hF, 4'd3);
    testBurst(4'h5, 4'd1);
    testBurst(4'h7, 4'd0);
    testBurst(4'h8, 4'd5);
    testBurst(4'hA, 4'd2);
    testNoChannels();
    testPeriod();
    testStall();
    testOverrun();
    finish();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

endmodule